// File: doc/BRIEF.md
# Dual-Clock Byte-Lane RAM with Configurable Read-During-Write Output

This block is a 1024 x 18-bit synchronous memory with two ports. Each port has its own clock, and both reach the same storage. A port has an enable, four byte-lane write enables, a 10-bit address, 16 data bits with 2 parity bits in, and the same widths out. Each stored word is two 9-bit lanes. The low lane holds data bits 7:0 with parity bit 0. The high lane holds data bits 15:8 with parity bit 1.

A parameter for each port sets what the output shows while that port writes: the new word, the old word, or the previous output left unchanged. The output latch can be loaded with a parameter value through a synchronous reset. A parameter adds an output register with its own clock enable, which adds one cycle of latency.

A second configuration turns the block into a 512 x 36-bit memory with one read port and one write port. Port A reads on its clock. Port B writes on its clock. Same-address collisions between the two clock domains are left to the user.

Top module: `dp_ram18`

## Requirements
- R1: In dual-port mode (SDP_MODE=0), a word written through either port is read back through the other port at the same address.
- R2: While a port's enable is low, that port writes nothing and its latch keeps its value. Without the output register, the data outputs hold.
- R3: A write needs the enable and a lane enable high at the clock edge. Lane 0 (data 7:0 with parity 0) is written when we[0] or we[2] is high. Lane 1 (data 15:8 with parity 1) is written when we[1] or we[3] is high. An unselected lane keeps its contents.
- R4: In write-first mode (WMODE=0), the latch loaded by a write holds the stored word after the write: new lanes where enabled, old lanes elsewhere.
- R5: In read-first mode (WMODE=1), the latch loaded by a write holds the word as it was before the write.
- R6: In no-change mode (WMODE=2), a write leaves the latch unchanged.
- R7: With the enable high and no lane enabled, the latch loads the addressed word one clock after the edge, whatever the mode.
- R8: Without the output register, reset together with enable loads RSTVAL into the latch. A write in that cycle still takes place.
- R9: With OREG=1, the output comes from a register that loads the latch on clock edges where the register enable is high. Reset loads RSTVAL into that register and takes priority over the register enable. The reset does not need the port enable.
- R10: In simple dual-port mode (SDP_MODE=1), row r is words 2r and 2r+1. Port B writes a row at addr_b[9:1]. we_b[0..3] select lanes 0..3, where lanes 0-1 come from the port A data inputs (even word) and lanes 2-3 come from the port B data inputs (odd word). Port A reads row addr_a[9:1] on clk_a and shows the even word on the A outputs and the odd word on the B outputs.
- R11: In simple dual-port mode, rst_a and oce_a drive reset and register enable for both output halves. The A half resets to RSTVAL_A and the B half resets to RSTVAL_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock (read clock in simple dual-port mode) |
| en_a | input | 1 | Port A enable |
| rst_a | input | 1 | Port A synchronous output reset |
| oce_a | input | 1 | Port A output register enable |
| we_a | input | 4 | Port A lane write enables |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | 16 | Port A write data |
| dinp_a | input | 2 | Port A write parity |
| dout_a | output | 16 | Port A read data |
| doutp_a | output | 2 | Port A read parity |
| clk_b | input | 1 | Port B clock (write clock in simple dual-port mode) |
| en_b | input | 1 | Port B enable |
| rst_b | input | 1 | Port B synchronous output reset |
| oce_b | input | 1 | Port B output register enable |
| we_b | input | 4 | Port B lane write enables |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | 16 | Port B write data |
| dinp_b | input | 2 | Port B write parity |
| dout_b | output | 16 | Port B read data |
| doutp_b | output | 2 | Port B read parity |

## Verification
Three copies of the block run side by side so that every write mode and both output paths are covered: write-first with a direct latch, read-first with a register, no-change with a direct latch, and a packed read/write copy.

A full fill with all four lane enables comes first. After it, random traffic runs over a 16-word window, where the two ports hit each other's words often. This exposes which port sees which write and whether partial-lane writes merge correctly. Random enables, resets and register enables separate a held latch from a reloaded one and separate reset priority from a normal register load. In the packed copy, reads and writes go to a small set of rows, which checks lane placement within each row.

// File: rtl/dp_ram18.sv
module dp_ram18 #(
  parameter int          ADDR_W   = 10,
  parameter bit          SDP_MODE = 1'b0,
  parameter int          WMODE_A  = 0,
  parameter int          WMODE_B  = 0,
  parameter bit          OREG_A   = 1'b0,
  parameter bit          OREG_B   = 1'b0,
  parameter logic [17:0] RSTVAL_A = '0,
  parameter logic [17:0] RSTVAL_B = '0
) (
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              rst_a,
  input  logic              oce_a,
  input  logic [3:0]        we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [15:0]       din_a,
  input  logic [1:0]        dinp_a,
  output logic [15:0]       dout_a,
  output logic [1:0]        doutp_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              rst_b,
  input  logic              oce_b,
  input  logic [3:0]        we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [15:0]       din_b,
  input  logic [1:0]        dinp_b,
  output logic [15:0]       dout_b,
  output logic [1:0]        doutp_b
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WL    = 9;
  localparam int WW    = 2 * WL;

  function automatic logic [WW-1:0] lane_mix(input logic [WW-1:0] old_w,
                                             input logic [WW-1:0] new_w,
                                             input logic [1:0]    sel);
    lane_mix = {sel[1] ? new_w[WW-1:WL] : old_w[WW-1:WL],
                sel[0] ? new_w[WL-1:0]  : old_w[WL-1:0]};
  endfunction

  logic [WW-1:0] bank_b [DEPTH];
  logic [WW-1:0] lat_a, lat_b, q_a, q_b;

  wire [WW-1:0] wd_a = {dinp_a[1], din_a[15:8], dinp_a[0], din_a[7:0]};
  wire [WW-1:0] wd_b = {dinp_b[1], din_b[15:8], dinp_b[0], din_b[7:0]};

  wire q_clk_b = SDP_MODE ? clk_a : clk_b;
  wire q_rst_b = SDP_MODE ? rst_a : rst_b;
  wire q_oce_b = SDP_MODE ? oce_a : oce_b;

  generate
    if (!SDP_MODE) begin : g_tdp
      logic [WW-1:0] bank_a [DEPTH];
      wire [1:0]     sel_a = we_a[1:0] | we_a[3:2];
      wire [1:0]     sel_b = we_b[1:0] | we_b[3:2];
      wire           wr_a  = en_a & |sel_a;
      wire           wr_b  = en_b & |sel_b;
      wire [WW-1:0]  cur_a = bank_a[addr_a] ^ bank_b[addr_a];
      wire [WW-1:0]  cur_b = bank_a[addr_b] ^ bank_b[addr_b];
      wire [WW-1:0]  nxt_a = lane_mix(cur_a, wd_a, sel_a);
      wire [WW-1:0]  nxt_b = lane_mix(cur_b, wd_b, sel_b);

      always_ff @(posedge clk_a)
        if (wr_a) bank_a[addr_a] <= nxt_a ^ bank_b[addr_a];

      always_ff @(posedge clk_b)
        if (wr_b) bank_b[addr_b] <= nxt_b ^ bank_a[addr_b];

      always_ff @(posedge clk_a)
        if (en_a) begin
          if (rst_a && !OREG_A)          lat_a <= RSTVAL_A;
          else if (!wr_a || WMODE_A == 1) lat_a <= cur_a;
          else if (WMODE_A == 0)          lat_a <= nxt_a;
        end

      always_ff @(posedge clk_b)
        if (en_b) begin
          if (rst_b && !OREG_B)          lat_b <= RSTVAL_B;
          else if (!wr_b || WMODE_B == 1) lat_b <= cur_b;
          else if (WMODE_B == 0)          lat_b <= nxt_b;
        end
    end else begin : g_sdp
      wire [ADDR_W-2:0] rrow = addr_a[ADDR_W-1:1];
      wire [ADDR_W-2:0] wrow = addr_b[ADDR_W-1:1];

      always_ff @(posedge clk_b)
        if (en_b) begin
          if (|we_b[1:0])
            bank_b[{wrow, 1'b0}] <= lane_mix(bank_b[{wrow, 1'b0}], wd_a, we_b[1:0]);
          if (|we_b[3:2])
            bank_b[{wrow, 1'b1}] <= lane_mix(bank_b[{wrow, 1'b1}], wd_b, we_b[3:2]);
        end

      always_ff @(posedge clk_a)
        if (en_a) begin
          if (rst_a && !OREG_A) begin
            lat_a <= RSTVAL_A;
            lat_b <= RSTVAL_B;
          end else begin
            lat_a <= bank_b[{rrow, 1'b0}];
            lat_b <= bank_b[{rrow, 1'b1}];
          end
        end
    end

    if (OREG_A) begin : g_rega
      always_ff @(posedge clk_a)
        if (rst_a)      q_a <= RSTVAL_A;
        else if (oce_a) q_a <= lat_a;
    end else begin : g_lata
      assign q_a = lat_a;
    end

    if (OREG_B) begin : g_regb
      always_ff @(posedge q_clk_b)
        if (q_rst_b)      q_b <= RSTVAL_B;
        else if (q_oce_b) q_b <= lat_b;
    end else begin : g_latb
      assign q_b = lat_b;
    end
  endgenerate

  assign dout_a  = {q_a[16:9], q_a[7:0]};
  assign doutp_a = {q_a[17], q_a[8]};
  assign dout_b  = {q_b[16:9], q_b[7:0]};
  assign doutp_b = {q_b[17], q_b[8]};
endmodule

module dp_ram18_chk #(
  parameter bit          SDP_MODE = 1'b0,
  parameter int          WMODE_A  = 0,
  parameter int          WMODE_B  = 0,
  parameter bit          OREG_A   = 1'b0,
  parameter bit          OREG_B   = 1'b0,
  parameter logic [17:0] RSTVAL_A = '0,
  parameter logic [17:0] RSTVAL_B = '0
) (
  input logic        clk_a,
  input logic        en_a,
  input logic        rst_a,
  input logic        oce_a,
  input logic [3:0]  we_a,
  input logic [15:0] din_a,
  input logic [15:0] dout_a,
  input logic [1:0]  doutp_a,
  input logic        clk_b,
  input logic        en_b,
  input logic        rst_b,
  input logic        oce_b,
  input logic [3:0]  we_b,
  input logic [15:0] din_b,
  input logic [15:0] dout_b,
  input logic [1:0]  doutp_b
);
  localparam logic [17:0] RO_A = {RSTVAL_A[17], RSTVAL_A[8], RSTVAL_A[16:9], RSTVAL_A[7:0]};
  localparam logic [17:0] RO_B = {RSTVAL_B[17], RSTVAL_B[8], RSTVAL_B[16:9], RSTVAL_B[7:0]};

  logic [1:0] age_a = '0;
  logic [1:0] age_b = '0;
  always_ff @(posedge clk_a) if (age_a != 2'd3) age_a <= age_a + 2'd1;
  always_ff @(posedge clk_b) if (age_b != 2'd3) age_b <= age_b + 2'd1;

  wire [17:0] out_a = {doutp_a, dout_a};
  wire [17:0] out_b = {doutp_b, dout_b};

  generate
    if (!OREG_A) begin : g_a_lat
      p_hold_off_a_r2: assert property (@(posedge clk_a) disable iff (age_a < 2'd2)
        !en_a |=> $stable(out_a));
      p_rst_a_r8: assert property (@(posedge clk_a) disable iff (age_a < 2'd1)
        en_a && rst_a |=> out_a == RO_A);
    end else begin : g_a_reg
      p_reg_rst_a_r9: assert property (@(posedge clk_a) disable iff (age_a < 2'd1)
        rst_a |=> out_a == RO_A);
      p_reg_hold_a_r9: assert property (@(posedge clk_a) disable iff (age_a < 2'd2)
        !rst_a && !oce_a |=> $stable(out_a));
    end

    if (!SDP_MODE && !OREG_A && WMODE_A == 0) begin : g_a_wf
      p_wf_lane0_a_r4: assert property (@(posedge clk_a) disable iff (age_a < 2'd1)
        en_a && !rst_a && (we_a[0] || we_a[2]) |=> dout_a[7:0] == $past(din_a[7:0]));
    end
    if (!SDP_MODE && !OREG_A && WMODE_A == 2) begin : g_a_nc
      p_nc_hold_a_r6: assert property (@(posedge clk_a) disable iff (age_a < 2'd2)
        en_a && !rst_a && (|we_a) |=> $stable(out_a));
    end

    if (!SDP_MODE) begin : g_b
      if (!OREG_B) begin : g_b_lat
        p_hold_off_b_r2: assert property (@(posedge clk_b) disable iff (age_b < 2'd2)
          !en_b |=> $stable(out_b));
        p_rst_b_r8: assert property (@(posedge clk_b) disable iff (age_b < 2'd1)
          en_b && rst_b |=> out_b == RO_B);
      end else begin : g_b_reg
        p_reg_rst_b_r9: assert property (@(posedge clk_b) disable iff (age_b < 2'd1)
          rst_b |=> out_b == RO_B);
        p_reg_hold_b_r9: assert property (@(posedge clk_b) disable iff (age_b < 2'd2)
          !rst_b && !oce_b |=> $stable(out_b));
      end
      if (!OREG_B && WMODE_B == 0) begin : g_b_wf
        p_wf_lane0_b_r4: assert property (@(posedge clk_b) disable iff (age_b < 2'd1)
          en_b && !rst_b && (we_b[0] || we_b[2]) |=> dout_b[7:0] == $past(din_b[7:0]));
      end
    end else begin : g_sdp
      p_sdp_rst_hi_r11: assert property (@(posedge clk_a) disable iff (age_a < 2'd1)
        rst_a && (OREG_B || en_a) |=> out_b == RO_B);
    end
  endgenerate
endmodule

bind dp_ram18 dp_ram18_chk #(
  .SDP_MODE(SDP_MODE), .WMODE_A(WMODE_A), .WMODE_B(WMODE_B),
  .OREG_A(OREG_A), .OREG_B(OREG_B), .RSTVAL_A(RSTVAL_A), .RSTVAL_B(RSTVAL_B)
) u_chk (
  .clk_a(clk_a), .en_a(en_a), .rst_a(rst_a), .oce_a(oce_a), .we_a(we_a),
  .din_a(din_a), .dout_a(dout_a), .doutp_a(doutp_a),
  .clk_b(clk_b), .en_b(en_b), .rst_b(rst_b), .oce_b(oce_b), .we_b(we_b),
  .din_b(din_b), .dout_b(dout_b), .doutp_b(doutp_b)
);

// File: tb/dp_ram18_bench.sv
module dp_ram18_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        a_en = 0, a_rst = 0, a_oce = 0, b_en = 0, b_rst = 0, b_oce = 0;
  logic [3:0]  a_we = 0, b_we = 0;
  logic [9:0]  a_ad = 0, b_ad = 0;
  logic [15:0] a_d = 0, b_d = 0;
  logic [1:0]  a_p = 0, b_p = 0;
  logic        s_ren = 0, s_rst = 0, s_oce = 0, s_wen = 0;
  logic [3:0]  s_we = 0;
  logic [9:0]  s_ra = 0, s_wa = 0;
  logic [15:0] s_da = 0, s_db = 0;
  logic [1:0]  s_pa = 0, s_pb = 0;

  logic [15:0] o0a, o0b, o1a, o1b, osa, osb;
  logic [1:0]  p0a, p0b, p1a, p1b, psa, psb;

  dp_ram18 #(.WMODE_A(0), .WMODE_B(1), .OREG_A(0), .OREG_B(1),
             .RSTVAL_A(18'h2A5A5), .RSTVAL_B(18'h1C3E7)) u_dp_ram18 (
    .clk_a(clk), .en_a(a_en), .rst_a(a_rst), .oce_a(a_oce), .we_a(a_we), .addr_a(a_ad),
    .din_a(a_d), .dinp_a(a_p), .dout_a(o0a), .doutp_a(p0a),
    .clk_b(clk), .en_b(b_en), .rst_b(b_rst), .oce_b(b_oce), .we_b(b_we), .addr_b(b_ad),
    .din_b(b_d), .dinp_b(b_p), .dout_b(o0b), .doutp_b(p0b));

  dp_ram18 #(.WMODE_A(2), .WMODE_B(0), .OREG_A(0), .OREG_B(1),
             .RSTVAL_A(18'h12345), .RSTVAL_B(18'h0F0F0)) u_dp_ram18_nc (
    .clk_a(clk), .en_a(a_en), .rst_a(a_rst), .oce_a(a_oce), .we_a(a_we), .addr_a(a_ad),
    .din_a(a_d), .dinp_a(a_p), .dout_a(o1a), .doutp_a(p1a),
    .clk_b(clk), .en_b(b_en), .rst_b(b_rst), .oce_b(b_oce), .we_b(b_we), .addr_b(b_ad),
    .din_b(b_d), .dinp_b(b_p), .dout_b(o1b), .doutp_b(p1b));

  dp_ram18 #(.SDP_MODE(1), .OREG_A(1), .OREG_B(1),
             .RSTVAL_A(18'h15A5A), .RSTVAL_B(18'h2C3C3)) u_dp_ram18_sdp (
    .clk_a(clk), .en_a(s_ren), .rst_a(s_rst), .oce_a(s_oce), .we_a(4'h0), .addr_a(s_ra),
    .din_a(s_da), .dinp_a(s_pa), .dout_a(osa), .doutp_a(psa),
    .clk_b(clk), .en_b(s_wen), .rst_b(1'b0), .oce_b(1'b0), .we_b(s_we), .addr_b(s_wa),
    .din_b(s_db), .dinp_b(s_pb), .dout_b(osb), .doutp_b(psb));

  // reference model: words kept as {par1, byte1, par0, byte0}
  logic [17:0] mm [3][1024];
  logic [17:0] lat [3][2];
  logic [17:0] qq  [3][2];
  int          mode [2][2] = '{'{0, 1}, '{2, 0}};
  bit          oreg [2][2] = '{'{0, 1}, '{0, 1}};
  logic [17:0] rv   [2][2] = '{'{18'h2A5A5, 18'h1C3E7}, '{18'h12345, 18'h0F0F0}};
  localparam logic [17:0] SRV_A = 18'h15A5A;
  localparam logic [17:0] SRV_B = 18'h2C3C3;

  int n_checks = 0, n_err = 0;
  bit armed = 0, done = 0;

  function automatic logic [17:0] pack(input logic [15:0] d, input logic [1:0] p);
    return {p[1], d[15:8], p[0], d[7:0]};
  endfunction

  task automatic tdp_step(input int i, input int p, input logic en, input logic rst,
                          input logic oce, input logic [3:0] we, input logic [9:0] ad,
                          input logic [17:0] wd);
    logic [1:0]  s;
    logic [17:0] cur, nxt;
    s = we[1:0] | we[3:2];
    if (oreg[i][p]) begin
      if (rst)      qq[i][p] = rv[i][p];
      else if (oce) qq[i][p] = lat[i][p];
    end
    if (en) begin
      cur = mm[i][ad];
      nxt = {s[1] ? wd[17:9] : cur[17:9], s[0] ? wd[8:0] : cur[8:0]};
      if (s != 2'b00) mm[i][ad] = nxt;
      if (rst && !oreg[i][p])                lat[i][p] = rv[i][p];
      else if (s == 2'b00 || mode[i][p] == 1) lat[i][p] = cur;
      else if (mode[i][p] == 0)               lat[i][p] = nxt;
    end
  endtask

  always @(posedge clk) begin
    tdp_step(0, 0, a_en, a_rst, a_oce, a_we, a_ad, pack(a_d, a_p));
    tdp_step(0, 1, b_en, b_rst, b_oce, b_we, b_ad, pack(b_d, b_p));
    tdp_step(1, 0, a_en, a_rst, a_oce, a_we, a_ad, pack(a_d, a_p));
    tdp_step(1, 1, b_en, b_rst, b_oce, b_we, b_ad, pack(b_d, b_p));
    if (s_rst) begin
      qq[2][0] = SRV_A; qq[2][1] = SRV_B;
    end else if (s_oce) begin
      qq[2][0] = lat[2][0]; qq[2][1] = lat[2][1];
    end
    if (s_ren) begin
      lat[2][0] = mm[2][{s_ra[9:1], 1'b0}];
      lat[2][1] = mm[2][{s_ra[9:1], 1'b1}];
    end
    if (s_wen) begin
      if (|s_we[1:0]) begin
        if (s_we[0]) mm[2][{s_wa[9:1], 1'b0}][8:0]  = pack(s_da, s_pa)[8:0];
        if (s_we[1]) mm[2][{s_wa[9:1], 1'b0}][17:9] = pack(s_da, s_pa)[17:9];
      end
      if (s_we[2]) mm[2][{s_wa[9:1], 1'b1}][8:0]  = pack(s_db, s_pb)[8:0];
      if (s_we[3]) mm[2][{s_wa[9:1], 1'b1}][17:9] = pack(s_db, s_pb)[17:9];
    end
  end

  task automatic check(input string tag, input logic [15:0] d, input logic [1:0] p,
                       input logic [17:0] w);
    logic [17:0] exp;
    exp = {w[17], w[8], w[16:9], w[7:0]};
    n_checks++;
    if ({p, d} !== exp) begin
      n_err++;
      $display("FAIL %s: got %05h expected %05h at %0t", tag, {p, d}, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    check("R1/R2/R3/R4/R7/R8 wf port A", o0a, p0a, lat[0][0]);
    check("R1/R2/R3/R5/R7/R9 rf port B", o0b, p0b, qq[0][1]);
    check("R1/R3/R6/R8 nc port A",       o1a, p1a, lat[1][0]);
    check("R1/R4/R9 wf port B",          o1b, p1b, qq[1][1]);
    check("R10/R11 sdp even word",       osa, psa, qq[2][0]);
    check("R10/R11 sdp odd word",        osb, psb, qq[2][1]);
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // fill every word and row
    for (int k = 0; k < 512; k++) begin
      @(posedge clk); #2;
      a_en = 1; b_en = 1; a_rst = 0; b_rst = 0; a_oce = 1; b_oce = 1;
      a_we = 4'hF; b_we = 4'hF; a_ad = 10'(k); b_ad = 10'(k + 512);
      a_d = 16'($urandom); a_p = 2'($urandom); b_d = 16'($urandom); b_p = 2'($urandom);
      s_ren = 1; s_rst = 0; s_oce = 1; s_wen = 1; s_we = 4'hF;
      s_ra = 10'd0; s_wa = 10'(2 * k);
      s_da = 16'($urandom); s_pa = 2'($urandom); s_db = 16'($urandom); s_pb = 2'($urandom);
    end
    @(posedge clk); #2;
    a_we = 0; b_we = 0; s_wen = 0; a_ad = 10'd3; b_ad = 10'd700; s_ra = 10'd6;
    repeat (2) @(posedge clk);
    #2;
    // reset state: all outputs take their reset values (R8, R9, R11)
    a_rst = 1; b_rst = 1; s_rst = 1;
    @(posedge clk); #1;
    armed = 1;
    #1;
    a_rst = 0; b_rst = 0; s_rst = 0;
    // random traffic on a small window
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #2;
      a_en  = ($urandom % 100) < 85;  b_en  = ($urandom % 100) < 85;
      a_rst = ($urandom % 100) < 8;   b_rst = ($urandom % 100) < 8;
      a_oce = ($urandom % 100) < 70;  b_oce = ($urandom % 100) < 70;
      a_we  = ($urandom % 2) ? 4'($urandom) : 4'h0;
      b_we  = ($urandom % 2) ? 4'($urandom) : 4'h0;
      a_ad  = 10'($urandom % 16);
      b_ad  = 10'($urandom % 16);
      if (b_ad == a_ad) b_ad = b_ad ^ 10'd1;
      a_d = 16'($urandom); a_p = 2'($urandom); b_d = 16'($urandom); b_p = 2'($urandom);
      s_ren = ($urandom % 100) < 85; s_wen = ($urandom % 100) < 85;
      s_rst = ($urandom % 100) < 8;  s_oce = ($urandom % 100) < 70;
      s_we  = ($urandom % 2) ? 4'($urandom) : 4'h0;
      s_ra  = 10'($urandom % 16); s_wa = 10'($urandom % 16);
      s_da = 16'($urandom); s_pa = 2'($urandom); s_db = 16'($urandom); s_pb = 2'($urandom);
    end
    @(posedge clk); #3;
    done = 1;
    summary();
    $finish;
  end
endmodule